// File: doc/BRIEF.md
# Interrupt Trigger Sensing Configuration

This block keeps one two-bit trigger code per interrupt ID and uses it to turn raw interrupt lines into pending requests. A line set to level mode is pending for as long as its synchronised input stays high. A line set to edge mode latches a pending bit on a low-to-high transition, and the bit stays set until the acknowledge logic clears it. The lowest IDs are reserved for software-generated interrupts. Their code is fixed and cannot be written.

Software reaches the trigger codes through a plain word-wide write/read port, with sixteen codes packed into each 32-bit word. Every raw line first passes through a two-flop synchroniser. The acknowledge logic drives a per-ID clear strobe. The pending vector goes on to the prioritisation logic, which lies outside this block.

Top module: `irq_trig_sense`

## Requirements
- R1: Configuration word w holds IDs 16w to 16w+15. ID i sits in bits [2(i mod 16)+1 : 2(i mod 16)] of its word, and `cfg_rdata` returns the word selected by `cfg_addr`.
- R2: The fields of software-generated IDs (0 to NUM_SGI-1) always read 2'b10, and writes to them are ignored.
- R3: For every other ID, bit 0 of the field always reads 1 and only bit 1 can be written. Code 2'b01 selects active-high level sensing and code 2'b11 selects rising-edge sensing.
- R4: A synchronous reset sets every writable field to 2'b01, clears all edge latches, and drives `pend_out` to zero.
- R5: Raw inputs pass through two flops before any use. A level-mode input that rises before clock edge 1 shows as pending after edge 2 and not after edge 1.
- R6: A level-mode ID is pending exactly while its synchronised input is high. A clear strobe has no effect on it.
- R7: An edge-mode ID whose input rises before edge 1 becomes pending after edge 3. It stays pending after the input falls.
- R8: A clear strobe on an edge-mode ID drops its pending bit at the next clock edge. An input held high does not set the bit again.
- R9: A rising edge that is latched at the same edge as a clear strobe leaves the ID pending.
- R10: Software-generated IDs latch their input line on a rising edge and are cleared in the same way as edge-mode IDs.
- R11: The edge latch of a level-mode ID is held clear. After a switch back to edge mode, the ID stays not pending until a new rising edge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for a configuration word |
| cfg_addr | input | AW | Word index for both write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed word (combinational) |
| irq_in | input | NUM_IDS | Raw interrupt lines |
| pend_clr | input | NUM_IDS | Per-ID pending clear strobe |
| pend_out | output | NUM_IDS | Pending request vector |

## Verification
A configuration write takes effect at the edge where it is accepted, and read data follows combinationally from that point. A level-mode result is due two edges after the input changes. An edge-mode result is due three edges after the input changes. A clear takes effect one edge after the strobe. The bench changes inputs one time unit after a rising edge and samples one time unit after each later edge. It counts edges explicitly: it checks that a result is still absent one edge before it is due, and present at the edge where it is due.

// File: rtl/trig_sense_pkg.sv
package trig_sense_pkg;

    localparam int WORD_W          = 32;
    localparam int FIELD_W         = 2;
    localparam int FIELDS_PER_WORD = WORD_W / FIELD_W;

    typedef enum logic [FIELD_W-1:0] {
        TRIG_RSVD  = 2'b00,
        TRIG_LEVEL = 2'b01,
        TRIG_SOFT  = 2'b10,
        TRIG_EDGE  = 2'b11
    } trig_code_e;

    typedef struct packed {
        logic              we;
        logic [WORD_W-1:0] data;
    } cfg_wr_t;

    // Extract the writable (edge/level) bit of one slot from a config word.
    function automatic logic edge_bit_of(input logic [WORD_W-1:0] word, input int slot);
        return word[FIELD_W*slot + 1];
    endfunction

    function automatic trig_code_e code_of(input logic is_soft, input logic edge_sel);
        if (is_soft)  return TRIG_SOFT;
        if (edge_sel) return TRIG_EDGE;
        return TRIG_LEVEL;
    endfunction

endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank
    import trig_sense_pkg::*;
#(
    parameter int NUM_IDS   = 32,
    parameter int NUM_SGI   = 16,
    parameter int NUM_WORDS = NUM_IDS / FIELDS_PER_WORD,
    parameter int AW        = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_wr_t           wr,
    input  logic [AW-1:0]     addr,
    output logic [WORD_W-1:0] rdata,
    output logic [NUM_IDS-1:0] edge_mode
);

    trig_code_e             code_v [NUM_IDS];
    logic [WORD_W-1:0]      word_v [NUM_WORDS];

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
        localparam int WIDX = i / FIELDS_PER_WORD;
        localparam int SLOT = i % FIELDS_PER_WORD;
        if (i < NUM_SGI) begin : g_soft
            assign edge_mode[i] = 1'b1;
            assign code_v[i]    = code_of(1'b1, 1'b0);
        end else begin : g_periph
            logic edge_q;
            always_ff @(posedge clk) begin
                if (rst)
                    edge_q <= 1'b0;
                else if (wr.we && addr == AW'(WIDX))
                    edge_q <= edge_bit_of(wr.data, SLOT);
            end
            assign edge_mode[i] = edge_q;
            assign code_v[i]    = code_of(1'b0, edge_q);
        end
    end

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        always_comb begin
            for (int s = 0; s < FIELDS_PER_WORD; s++)
                word_v[w][FIELD_W*s +: FIELD_W] = code_v[w*FIELDS_PER_WORD + s];
        end
    end

    always_comb begin
        rdata = '0;
        for (int w = 0; w < NUM_WORDS; w++)
            if (addr == AW'(w)) rdata = word_v[w];
    end

    // R3: the trigger mode moves only on an accepted write
    a_r3_mode_hold: assert property (@(posedge clk) disable iff (rst)
        !wr.we |=> $stable(edge_mode));

endmodule

// File: rtl/trig_in_sync.sv
module trig_in_sync #(
    parameter int NUM_IDS = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IDS-1:0] raw,
    output logic [NUM_IDS-1:0] lvl,
    output logic [NUM_IDS-1:0] lvl_d
);

    logic [NUM_IDS-1:0] meta_q;
    logic [NUM_IDS-1:0] lvl_q;
    logic [NUM_IDS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign lvl   = lvl_q;
    assign lvl_d = prev_q;

endmodule

// File: rtl/trig_pend_track.sv
module trig_pend_track #(
    parameter int NUM_IDS = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IDS-1:0] edge_mode,
    input  logic [NUM_IDS-1:0] lvl,
    input  logic [NUM_IDS-1:0] lvl_d,
    input  logic [NUM_IDS-1:0] clr,
    output logic [NUM_IDS-1:0] pend
);

    logic [NUM_IDS-1:0] set_v;
    logic [NUM_IDS-1:0] latch_q;

    assign set_v = edge_mode & lvl & ~lvl_d;

    // A new edge wins over a clear; level-mode IDs keep the latch empty.
    always_ff @(posedge clk) begin
        if (rst)
            latch_q <= '0;
        else
            latch_q <= (latch_q & ~clr & edge_mode) | set_v;
    end

    assign pend = (edge_mode & latch_q) | (~edge_mode & lvl);

    // R7 / R9: a detected rising edge is always latched
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latch_q & $past(set_v)) == $past(set_v)));

    // R8: a strobe without a fresh edge empties the latch
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latch_q & $past(clr & ~set_v)) == '0));

    // R7: a latched edge-mode bit survives until cleared
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latch_q & $past(latch_q & ~clr & edge_mode))
                  == $past(latch_q & ~clr & edge_mode)));

    // R11: a level-mode ID never holds a latched bit
    a_r11_level_empty: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((latch_q & $past(~edge_mode)) == '0));

endmodule

// File: rtl/irq_trig_sense.sv
module irq_trig_sense
    import trig_sense_pkg::*;
#(
    parameter  int NUM_IDS   = 32,
    parameter  int NUM_SGI   = 16,
    localparam int NUM_WORDS = NUM_IDS / FIELDS_PER_WORD,
    localparam int AW        = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [AW-1:0]      cfg_addr,
    input  logic [WORD_W-1:0]  cfg_wdata,
    output logic [WORD_W-1:0]  cfg_rdata,
    input  logic [NUM_IDS-1:0] irq_in,
    input  logic [NUM_IDS-1:0] pend_clr,
    output logic [NUM_IDS-1:0] pend_out
);

    cfg_wr_t            wr;
    logic [NUM_IDS-1:0] edge_mode;
    logic [NUM_IDS-1:0] lvl;
    logic [NUM_IDS-1:0] lvl_d;

    assign wr.we   = cfg_we;
    assign wr.data = cfg_wdata;

    trig_cfg_bank #(
        .NUM_IDS   (NUM_IDS),
        .NUM_SGI   (NUM_SGI),
        .NUM_WORDS (NUM_WORDS),
        .AW        (AW)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .addr      (cfg_addr),
        .rdata     (cfg_rdata),
        .edge_mode (edge_mode)
    );

    trig_in_sync #(.NUM_IDS(NUM_IDS)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw   (irq_in),
        .lvl   (lvl),
        .lvl_d (lvl_d)
    );

    trig_pend_track #(.NUM_IDS(NUM_IDS)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .edge_mode (edge_mode),
        .lvl       (lvl),
        .lvl_d     (lvl_d),
        .clr       (pend_clr),
        .pend      (pend_out)
    );

endmodule

// File: tb/tb_irq_trig_sense.sv
module tb_irq_trig_sense;

    localparam int N  = 32;
    localparam int AW = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic [N-1:0]  irq_in = '0;
    logic [N-1:0]  pend_clr = '0;
    logic [N-1:0]  pend_out;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_trig_sense #(.NUM_IDS(N), .NUM_SGI(16)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_in(irq_in),
        .pend_clr(pend_clr), .pend_out(pend_out)
    );

    // {addr, write data, expected read-back}
    localparam int NV = 7;
    localparam logic [64:0] VEC [NV] = '{
        {1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {1'b1, 32'h0000_0000, 32'h5555_5555},
        {1'b1, 32'hAAAA_AAAA, 32'hFFFF_FFFF},
        {1'b1, 32'h0000_000C, 32'h5555_555D},
        {1'b0, 32'h0000_0000, 32'hAAAA_AAAA},
        {1'b0, 32'hFFFF_FFFF, 32'hAAAA_AAAA},
        {1'b1, 32'h0000_0000, 32'h5555_5555}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        // R4: reset state
        cfg_addr = 1'b1;
        #0;
        chk("R4 pend", pend_out, 32'h0);
        chk("R4 cfg", cfg_rdata, 32'h5555_5555);

        // R1 R2 R3: register vectors
        for (int k = 0; k < NV; k++) begin
            wr(VEC[k][64], VEC[k][63:32]);
            chk(VEC[k][64] ? "R1/R3 word" : "R2 word", cfg_rdata, VEC[k][31:0]);
        end

        // R5 R6: level mode on ID 20
        irq_in[20] = 1'b1;
        step(); chk("R5 early", {31'b0, pend_out[20]}, 32'd0);
        step(); chk("R5 due", {31'b0, pend_out[20]}, 32'd1);
        pend_clr[20] = 1'b1; step(); pend_clr[20] = 1'b0;
        chk("R6 clr ignored", {31'b0, pend_out[20]}, 32'd1);
        irq_in[20] = 1'b0;
        step(); step(); chk("R6 follows low", {31'b0, pend_out[20]}, 32'd0);

        // R7 R8: edge mode on ID 21
        wr(1'b1, 32'h0000_0800);
        chk("R3 edge code", cfg_rdata, 32'h5555_5D55);
        irq_in[21] = 1'b1;
        step(); step(); chk("R7 early", {31'b0, pend_out[21]}, 32'd0);
        step(); chk("R7 due", {31'b0, pend_out[21]}, 32'd1);
        irq_in[21] = 1'b0;
        repeat (4) step();
        chk("R7 held", {31'b0, pend_out[21]}, 32'd1);
        pend_clr[21] = 1'b1; step(); pend_clr[21] = 1'b0;
        chk("R8 cleared", {31'b0, pend_out[21]}, 32'd0);

        // R9: clear held while a new edge is latched
        pend_clr[21] = 1'b1; irq_in[21] = 1'b1;
        step(); step(); step();
        chk("R9 set wins", {31'b0, pend_out[21]}, 32'd1);
        pend_clr[21] = 1'b0;
        step(); chk("R9 stays", {31'b0, pend_out[21]}, 32'd1);
        pend_clr[21] = 1'b1; step(); pend_clr[21] = 1'b0;
        step(); chk("R8 no re-set while high", {31'b0, pend_out[21]}, 32'd0);
        irq_in[21] = 1'b0; step(); step();

        // R10: software-generated ID 3
        irq_in[3] = 1'b1;
        step(); step(); chk("R10 early", {31'b0, pend_out[3]}, 32'd0);
        step(); chk("R10 due", {31'b0, pend_out[3]}, 32'd1);
        irq_in[3] = 1'b0; repeat (3) step();
        chk("R10 held", {31'b0, pend_out[3]}, 32'd1);
        pend_clr[3] = 1'b1; step(); pend_clr[3] = 1'b0;
        chk("R10 cleared", {31'b0, pend_out[3]}, 32'd0);

        // R11: mode switch with a latched edge
        irq_in[21] = 1'b1; step(); step(); step();
        chk("R11 latched", {31'b0, pend_out[21]}, 32'd1);
        irq_in[21] = 1'b0; step(); step();
        wr(1'b1, 32'h0000_0000);
        chk("R11 level low", {31'b0, pend_out[21]}, 32'd0);
        wr(1'b1, 32'h0000_0800);
        chk("R11 back to edge", {31'b0, pend_out[21]}, 32'd0);
        step();
        chk("R11 all idle", pend_out, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule